// File: doc/BRIEF.md
# Execution-Origin Access Gate

This block holds a single permission bit that decides whether a protected peripheral, here an SPI master with its register window, may be used. It watches the CPU instruction-fetch bus. The bit is set when the CPU fetches an instruction from one configured trampoline address. It is cleared when the CPU fetches an instruction from anywhere in the RAM range. Between those events the bit keeps its value. Which bus address the CPU is accessing plays no part in granting permission. Only the origin of executed code does.

While permission is held, CPU bus accesses to the peripheral's register window go through unchanged. The chip-select, clock and data lines between the SPI master and its slave also pass straight through. While permission is withheld, bus accesses are answered locally: reads return zero with a ready response, and writes are dropped. The SPI lines are held idle in both directions. The permission bit is also brought out as a port, so other hardware resources can be gated by the same state.

Top module: `exec_gate`

## Requirements
- R1: While reset is asserted, and after it is released, `access_en` is 0 until a trampoline fetch is seen.
- R2: A cycle with `fetch_valid` and `fetch_instr` high and `fetch_addr` equal to `TRAMP_ADDR` sets `access_en` to 1 from the next cycle on, unless that address is inside RAM.
- R3: A cycle with `fetch_valid` and `fetch_instr` high and `fetch_addr` in `[RAM_BASE, RAM_BASE+RAM_SIZE)` clears `access_en` from the next cycle on. This includes the case where the address is also `TRAMP_ADDR`.
- R4: `access_en` keeps its value in cycles that are not instruction fetches (`fetch_valid` or `fetch_instr` low), whatever the address. It also keeps its value for instruction fetches that neither hit the trampoline nor fall in RAM.
- R5: With `access_en` at 1, `per_cs`, `per_we`, `per_addr` and `per_wdata` equal the CPU-side inputs, and `cpu_rdata`/`cpu_ready` equal `per_rdata`/`per_ready`.
- R6: With `access_en` at 0, `per_cs`, `per_we`, `per_addr` and `per_wdata` are all 0, `cpu_rdata` is 0, and `cpu_ready` equals `cpu_cs`.
- R7: With `access_en` at 1, `spi_s_csn`, `spi_s_sclk`, `spi_s_mosi` follow the master-side inputs and `spi_m_miso` follows `spi_s_miso`, all without delay.
- R8: With `access_en` at 0, `spi_s_csn` is 1, `spi_s_sclk` is 0, `spi_s_mosi` is 0 and `spi_m_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch bus carries a valid access this cycle |
| fetch_instr | input | 1 | The access is an instruction fetch |
| fetch_addr | input | ADDR_W | Fetch address |
| cpu_cs | input | 1 | CPU selects the peripheral window |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | WIN_AW | Register offset in the window |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |
| cpu_ready | output | 1 | Ready returned to the CPU |
| per_cs | output | 1 | Select to the peripheral |
| per_we | output | 1 | Write strobe to the peripheral |
| per_addr | output | WIN_AW | Register offset to the peripheral |
| per_wdata | output | DATA_W | Write data to the peripheral |
| per_rdata | input | DATA_W | Peripheral read data |
| per_ready | input | 1 | Peripheral ready |
| spi_m_csn | input | 1 | Chip-select from the SPI master |
| spi_m_sclk | input | 1 | Clock from the SPI master |
| spi_m_mosi | input | 1 | Data out from the SPI master |
| spi_m_miso | output | 1 | Data in to the SPI master |
| spi_s_csn | output | 1 | Chip-select to the slave |
| spi_s_sclk | output | 1 | Clock to the slave |
| spi_s_mosi | output | 1 | Data to the slave |
| spi_s_miso | input | 1 | Data from the slave |
| access_en | output | 1 | Permission state, usable by other resources |

## Verification
The bench builds the main instance with a 16-bit fetch address, a 1 KiB RAM at 0x8000 and the trampoline at 0x0040 outside RAM. With these values random fetch addresses hit the trampoline, the RAM range and its edges, and plain code space often enough to cover every transition. A second instance places its trampoline at 0x8010, inside RAM, which brings the overlap rule within reach. At that address a fetch must clear permission rather than set it.

// File: rtl/exec_gate.sv
module exec_gate #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WIN_AW = 8,
  parameter logic [ADDR_W-1:0] TRAMP_ADDR = 'h0000_0100,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 'h4000_0000,
  parameter logic [ADDR_W:0]   RAM_SIZE   = 'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              fetch_instr,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              cpu_cs,
  input  logic              cpu_we,
  input  logic [WIN_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              per_cs,
  output logic              per_we,
  output logic [WIN_AW-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata,
  input  logic              per_ready,
  input  logic              spi_m_csn,
  input  logic              spi_m_sclk,
  input  logic              spi_m_mosi,
  output logic              spi_m_miso,
  output logic              spi_s_csn,
  output logic              spi_s_sclk,
  output logic              spi_s_mosi,
  input  logic              spi_s_miso,
  output logic              access_en
);

  localparam logic [ADDR_W:0] RAM_LO = {1'b0, RAM_BASE};
  localparam logic [ADDR_W:0] RAM_HI = RAM_LO + RAM_SIZE;

  logic is_fetch, hit_ram, hit_tramp, en_q;

  assign is_fetch  = fetch_valid & fetch_instr;
  assign hit_ram   = ({1'b0, fetch_addr} >= RAM_LO) && ({1'b0, fetch_addr} < RAM_HI);
  assign hit_tramp = (fetch_addr == TRAMP_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    en_q <= 1'b0;
    else if (is_fetch && hit_ram)  en_q <= 1'b0;
    else if (is_fetch && hit_tramp) en_q <= 1'b1;
  end

  assign access_en = en_q;

  assign per_cs    = cpu_cs & en_q;
  assign per_we    = cpu_we & en_q;
  assign per_addr  = en_q ? cpu_addr  : '0;
  assign per_wdata = en_q ? cpu_wdata : '0;
  assign cpu_rdata = en_q ? per_rdata : '0;
  assign cpu_ready = en_q ? per_ready : cpu_cs;

  assign spi_s_csn  = en_q ? spi_m_csn  : 1'b1;
  assign spi_s_sclk = en_q & spi_m_sclk;
  assign spi_s_mosi = en_q & spi_m_mosi;
  assign spi_m_miso = en_q & spi_s_miso;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !access_en); // R1
  AST_TRAMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_instr && fetch_addr == TRAMP_ADDR && !hit_ram) |=> access_en); // R2
  AST_RAM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_instr && hit_ram) |=> !access_en); // R3
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && fetch_instr) |=> $stable(access_en)); // R4
  AST_BUS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !access_en |-> (!per_cs && !per_we && cpu_rdata == '0 && cpu_ready == cpu_cs)); // R6
  AST_SPI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !access_en |-> (spi_s_csn && !spi_s_sclk && !spi_s_mosi && !spi_m_miso)); // R8

endmodule

// File: tb/exec_gate_tb.sv
module exec_gate_tb_top;
  localparam logic [15:0] TRAMP  = 16'h0040;
  localparam logic [15:0] TRAMP2 = 16'h8010;
  localparam logic [15:0] RBASE  = 16'h8000;
  localparam logic [16:0] RSIZE  = 17'h00400;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic fv, fi;
  logic [15:0] fa;
  logic ccs, cwe;
  logic [7:0] cad;
  logic [31:0] cwd, prd;
  logic prdy, mcsn, msclk, mmosi, smiso;
  logic [31:0] crd, pwd;
  logic crdy, pcs, pwe, mmiso, scsn, ssclk, smosi, en, en2;
  logic [7:0] pad;
  logic [31:0] crd2, pwd2;
  logic crdy2, pcs2, pwe2, mmiso2, scsn2, ssclk2, smosi2;
  logic [7:0] pad2;

  int checks = 0, errors = 0;
  logic exp_en = 1'b0, exp_en2 = 1'b0;

  exec_gate #(.ADDR_W(16), .DATA_W(32), .WIN_AW(8), .TRAMP_ADDR(TRAMP),
              .RAM_BASE(RBASE), .RAM_SIZE(RSIZE)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_instr(fi), .fetch_addr(fa),
    .cpu_cs(ccs), .cpu_we(cwe), .cpu_addr(cad), .cpu_wdata(cwd),
    .cpu_rdata(crd), .cpu_ready(crdy), .per_cs(pcs), .per_we(pwe),
    .per_addr(pad), .per_wdata(pwd), .per_rdata(prd), .per_ready(prdy),
    .spi_m_csn(mcsn), .spi_m_sclk(msclk), .spi_m_mosi(mmosi), .spi_m_miso(mmiso),
    .spi_s_csn(scsn), .spi_s_sclk(ssclk), .spi_s_mosi(smosi), .spi_s_miso(smiso),
    .access_en(en));

  exec_gate #(.ADDR_W(16), .DATA_W(32), .WIN_AW(8), .TRAMP_ADDR(TRAMP2),
              .RAM_BASE(RBASE), .RAM_SIZE(RSIZE)) dut_ovl_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_instr(fi), .fetch_addr(fa),
    .cpu_cs(ccs), .cpu_we(cwe), .cpu_addr(cad), .cpu_wdata(cwd),
    .cpu_rdata(crd2), .cpu_ready(crdy2), .per_cs(pcs2), .per_we(pwe2),
    .per_addr(pad2), .per_wdata(pwd2), .per_rdata(prd), .per_ready(prdy),
    .spi_m_csn(mcsn), .spi_m_sclk(msclk), .spi_m_mosi(mmosi), .spi_m_miso(mmiso2),
    .spi_s_csn(scsn2), .spi_s_sclk(ssclk2), .spi_s_mosi(smosi2), .spi_s_miso(smiso),
    .access_en(en2));

  function automatic logic in_ram(logic [15:0] a);
    return ({1'b0, a} >= {1'b0, RBASE}) && ({1'b0, a} < ({1'b0, RBASE} + RSIZE));
  endfunction

  function automatic logic next_en(logic cur, logic v, logic i, logic [15:0] a, logic [15:0] t);
    if (v && i && in_ram(a)) return 1'b0;
    if (v && i && a == t)    return 1'b1;
    return cur;
  endfunction

  function automatic logic [46:0] exp_bus(logic e);
    // {per_cs, per_we, per_addr, per_wdata, cpu_ready, cpu_rdata[3:0]} packed loosely
    return e ? {ccs, cwe, cad, cwd, prdy, prd[3:0]} : {1'b0, 1'b0, 8'h00, 32'h0, ccs, 4'h0};
  endfunction

  function automatic logic [3:0] exp_spi(logic e);
    return e ? {mcsn, msclk, mmosi, smiso} : 4'b1000;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R1-R4 access_en", {63'd0, en}, {63'd0, exp_en});
    chk("R3 overlap access_en", {63'd0, en2}, {63'd0, exp_en2});
    if (exp_en) begin
      chk("R5 bus pass", {17'd0, pcs, pwe, pad, pwd, crdy, crd[3:0]}, {17'd0, exp_bus(1'b1)});
      chk("R5 rdata", {32'd0, crd}, {32'd0, prd});
      chk("R7 spi pass", {60'd0, scsn, ssclk, smosi, mmiso}, {60'd0, exp_spi(1'b1)});
    end else begin
      chk("R6 bus block", {17'd0, pcs, pwe, pad, pwd, crdy, crd[3:0]}, {17'd0, exp_bus(1'b0)});
      chk("R6 rdata", {32'd0, crd}, 64'd0);
      chk("R8 spi idle", {60'd0, scsn, ssclk, smosi, mmiso}, {60'd0, exp_spi(1'b0)});
    end
  endtask

  task automatic rand_side();
    ccs = 1'($urandom); cwe = 1'($urandom); cad = 8'($urandom);
    cwd = $urandom; prd = $urandom; prdy = 1'($urandom);
    mcsn = 1'($urandom); msclk = 1'($urandom); mmosi = 1'($urandom); smiso = 1'($urandom);
  endtask

  task automatic step(logic v, logic i, logic [15:0] a);
    @(negedge clk);
    fv = v; fi = i; fa = a;
    rand_side();
    #2;
    check_outputs();
    @(posedge clk);
    exp_en  = next_en(exp_en,  v, i, a, TRAMP);
    exp_en2 = next_en(exp_en2, v, i, a, TRAMP2);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 6)
      0: return TRAMP;
      1: return TRAMP2;
      2: return 16'(RBASE + 16'($urandom % 1024));
      3: return 16'(RBASE + 16'h03FF);
      4: return 16'(RBASE + 16'h0400);
      default: return 16'($urandom % 16'h2000);
    endcase
  endfunction

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    fv = 0; fi = 0; fa = '0;
    rand_side();
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset en", {63'd0, en}, 64'd0);
    chk("R8 reset spi", {60'd0, scsn, ssclk, smosi, mmiso}, {60'd0, exp_spi(1'b0)});
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, TRAMP);           // R4 data access at trampoline: no set
    step(1, 1, TRAMP);           // R2 set
    step(1, 0, RBASE);           // R4 data read in RAM: stays set
    step(0, 1, RBASE);           // R4 no valid
    step(1, 1, 16'h1234);        // R4 plain code: holds
    step(1, 1, 16'(RBASE + 16'h03FF)); // R3 top of RAM clears
    step(1, 1, TRAMP);
    step(1, 1, 16'(RBASE + 16'h0400)); // R4 just past RAM: holds
    step(1, 1, TRAMP2);          // R3 overlap: both cleared
    step(1, 1, 16'h0000);
    for (int n = 0; n < 3000; n++)
      step(1'($urandom % 4 != 0), 1'($urandom % 3 != 0), pick_addr());
    @(negedge clk);
    rst_n = 1'b0;
    exp_en = 0; exp_en2 = 0;
    #2;
    chk("R1 reset again", {63'd0, en}, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule